// File: doc/BRIEF.md
# Per-Process Page Translation Unit

This block turns a 32-bit linear byte address into a physical byte address by looking up an on-chip translation table. The table is divided into one equal region per process; the row is chosen by placing the current process number above the page field of the linear address. Each row gives the physical page base together with a supervisor-only flag, a write-enable flag, a modified (dirty) flag and the number of the process that owns the row. A lookup takes one cycle to read the row and one cycle to check it. The result is reported with a one-cycle valid pulse, a physical address, a fault code and the dirty flag as it was read.

When paging is off, the linear address passes through unchanged. When paging is on, the lookup faults if the page field is beyond the region, if the row's owner stamp differs from the current process, if a non-supervisor access reaches a supervisor page, or if a write reaches a page that does not allow writes. A write that succeeds sets the row's dirty flag by a read-modify-write. Supervisor software fills or clears rows through a separate write port at any time. The defaults give 4 processes of 256 pages each (`ProcBits=2`, `PageRowBits=8`). The full-size setting is `ProcBits=7`, `PageRowBits=10`.

Top module: `page_xlate`

## Requirements
- R1: With paging on and no fault, the table row is {curProc, linAddr[12 +: PageRowBits]} and physAddr = {row[31:12], linAddr[11:0]}. The row layout is [31:12] page base, [11] supervisor-only, [10] write-allowed, [9] dirty, [8:7] reserved, [6:0] owner process.
- R2: A request sampled on one rising edge is published on the second edge after it. outValid is high for exactly one cycle per request.
- R3: With pagingEn low, physAddr equals linAddr, faultCode is 0 and outDirty is 0, whatever the table holds.
- R4: With paging on, a page field (linAddr[31:12]) of 2^PageRowBits or more gives faultCode 4. This fault has the highest priority.
- R5: With paging on, an owner stamp different from curProc gives faultCode 3. Process 0 is reserved, so curProc 0 always gives code 3. A row holding all zeros is therefore unmapped.
- R6: With paging on and privSup low, a row with bit 11 set gives faultCode 1. This is checked after R4 and R5.
- R7: With paging on, a write access (accType 1) to a row with bit 10 clear gives faultCode 2. This has the lowest priority. Read (0) and fetch (2) never raise it.
- R8: On any fault, physAddr and outDirty are 0.
- R9: A write access without fault sets bit 9 of its row. outDirty reports bit 9 as read at lookup, so a later lookup of that row shows 1.
- R10: The table write port stores tblData at row {tblProc, tblPage} only when tblWe and privSup are both high. Otherwise the table is unchanged.
- R11: If a supervisor table write and a dirty update fall in the same cycle, the table write is stored and the dirty update is dropped.
- R12: Reset clears every table row to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| linAddr | input | 32 | Linear byte address |
| accType | input | 2 | 0 read, 1 write, 2 fetch |
| pagingEn | input | 1 | 1 translates, 0 passes the address through |
| privSup | input | 1 | Supervisor privilege; also gates table writes |
| curProc | input | ProcBits | Current process number |
| tblWe | input | 1 | Table write strobe |
| tblProc | input | ProcBits | Process region of the row to write |
| tblPage | input | PageRowBits | Page index of the row to write |
| tblData | input | 32 | Row contents to store |
| outValid | output | 1 | One-cycle result strobe |
| physAddr | output | 32 | Physical byte address |
| faultCode | output | 3 | 0 none, 1 supervisor, 2 write-protect, 3 owner mismatch, 4 range |
| outDirty | output | 1 | Dirty flag of the row as read |

## Verification
The table has one write port, and two things compete for it. One is the dirty update of a write that reaches its check stage. The other is a supervisor table write. The bench issues a write access to one mapped row. In the very next cycle, while that access is being checked, it drives a table write to a different row. It then looks up both rows: the first must still report a clear dirty flag, and the second must return the newly stored base. Random traffic also sends table writes with privilege low and lookups with mixed privilege, process and paging settings. All of it is judged against a bench model of the table.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_SUPER = 3'd1,
    FLT_WPROT = 3'd2,
    FLT_OWNER = 3'd3,
    FLT_RANGE = 3'd4
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int STAMP_W   = 7;
  localparam int BIT_SUPER = 11;
  localparam int BIT_WREN  = 10;
  localparam int BIT_DIRTY = 9;

  typedef struct packed {
    logic captureReq;
    logic publish;
    logic memWrite;
    logic useDirty;
  } xlate_cmd_t;
endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       tblWe,
  input  logic       privSup,
  input  logic       dirtyNeed,
  output xlate_cmd_t cmd,
  output logic       outValid
);
  logic s1Valid;
  logic hostWr;
  logic dirtyReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= reqValid;
      outValid <= s1Valid;
    end
  end

  always_comb begin
    hostWr         = tblWe && privSup;
    dirtyReq       = s1Valid && dirtyNeed;
    cmd.captureReq = reqValid;
    cmd.publish    = s1Valid;
    cmd.memWrite   = hostWr || dirtyReq;
    cmd.useDirty   = dirtyReq && !hostWr;
  end
endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int ProcBits    = 2,
  parameter int PageRowBits = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xlate_cmd_t             cmd,
  input  logic [31:0]            linAddr,
  input  logic [1:0]             accType,
  input  logic                   pagingEn,
  input  logic                   privSup,
  input  logic [ProcBits-1:0]    curProc,
  input  logic [ProcBits-1:0]    tblProc,
  input  logic [PageRowBits-1:0] tblPage,
  input  logic [31:0]            tblData,
  output logic                   dirtyNeed,
  output logic [31:0]            physAddr,
  output logic [2:0]             faultCode,
  output logic                   outDirty
);
  localparam int RowBits = ProcBits + PageRowBits;
  localparam int Rows    = 1 << RowBits;
  localparam int HiLsb   = 12 + PageRowBits;

  logic [31:0]        tbl [Rows];
  logic [31:0]        rdData;
  logic [31:0]        s1Lin;
  logic [1:0]         s1Acc;
  logic               s1PagingEn;
  logic               s1Sup;
  logic [ProcBits-1:0] s1Proc;
  logic [RowBits-1:0] s1Row;
  logic [RowBits-1:0] rdRow;
  logic [RowBits-1:0] wrRow;
  logic [31:0]        wrData;
  fault_e             faultNow;

  assign rdRow = {curProc, linAddr[12 +: PageRowBits]};

  always_comb begin
    wrRow  = cmd.useDirty ? s1Row : {tblProc, tblPage};
    wrData = tblData;
    if (cmd.useDirty) begin
      wrData            = rdData;
      wrData[BIT_DIRTY] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Rows; i++) tbl[i] <= '0;
    end else if (cmd.memWrite) begin
      tbl[wrRow] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      s1Lin      <= '0;
      s1Acc      <= ACC_READ;
      s1PagingEn <= 1'b0;
      s1Sup      <= 1'b0;
      s1Proc     <= '0;
      s1Row      <= '0;
    end else if (cmd.captureReq) begin
      rdData     <= tbl[rdRow];
      s1Lin      <= linAddr;
      s1Acc      <= accType;
      s1PagingEn <= pagingEn;
      s1Sup      <= privSup;
      s1Proc     <= curProc;
      s1Row      <= rdRow;
    end
  end

  always_comb begin
    faultNow = FLT_NONE;
    if (s1PagingEn) begin
      if (s1Lin[31:HiLsb] != '0)
        faultNow = FLT_RANGE;
      else if (s1Proc == '0 || rdData[STAMP_W-1:0] != STAMP_W'(s1Proc))
        faultNow = FLT_OWNER;
      else if (rdData[BIT_SUPER] && !s1Sup)
        faultNow = FLT_SUPER;
      else if (s1Acc == ACC_WRITE && !rdData[BIT_WREN])
        faultNow = FLT_WPROT;
    end
    dirtyNeed = s1PagingEn && faultNow == FLT_NONE && s1Acc == ACC_WRITE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr  <= '0;
      faultCode <= FLT_NONE;
      outDirty  <= 1'b0;
    end else if (cmd.publish) begin
      faultCode <= faultNow;
      if (!s1PagingEn) begin
        physAddr <= s1Lin;
        outDirty <= 1'b0;
      end else if (faultNow == FLT_NONE) begin
        physAddr <= {rdData[31:12], s1Lin[11:0]};
        outDirty <= rdData[BIT_DIRTY];
      end else begin
        physAddr <= '0;
        outDirty <= 1'b0;
      end
    end
  end

  // R3: pass-through when paging is off
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rstN)
    cmd.publish && !s1PagingEn |=> physAddr == $past(s1Lin) && faultCode == FLT_NONE);
  // R5: reserved process 0 never translates
  a_r5_proc_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmd.publish && s1PagingEn && s1Proc == '0 |=> faultCode != FLT_NONE);
  // R9: a dirty update only comes from a paged write access
  a_r9_dirty_from_write: assert property (@(posedge clk) disable iff (!rstN)
    cmd.memWrite && cmd.useDirty |-> s1Acc == ACC_WRITE && s1PagingEn);
  // R1: the byte offset survives translation
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    cmd.publish && faultNow == FLT_NONE |=> physAddr[11:0] == $past(s1Lin[11:0]));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int ProcBits    = 2,
  parameter int PageRowBits = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [31:0]            linAddr,
  input  logic [1:0]             accType,
  input  logic                   pagingEn,
  input  logic                   privSup,
  input  logic [ProcBits-1:0]    curProc,
  input  logic                   tblWe,
  input  logic [ProcBits-1:0]    tblProc,
  input  logic [PageRowBits-1:0] tblPage,
  input  logic [31:0]            tblData,
  output logic                   outValid,
  output logic [31:0]            physAddr,
  output logic [2:0]             faultCode,
  output logic                   outDirty
);
  xlate_cmd_t cmd;
  logic       dirtyNeed;

  page_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tblWe(tblWe),
    .privSup(privSup), .dirtyNeed(dirtyNeed), .cmd(cmd), .outValid(outValid)
  );

  page_xlate_dp #(.ProcBits(ProcBits), .PageRowBits(PageRowBits)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .linAddr(linAddr), .accType(accType),
    .pagingEn(pagingEn), .privSup(privSup), .curProc(curProc),
    .tblProc(tblProc), .tblPage(tblPage), .tblData(tblData),
    .dirtyNeed(dirtyNeed), .physAddr(physAddr), .faultCode(faultCode),
    .outDirty(outDirty)
  );

  // R8: a faulted result carries no address and no dirty flag
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid && faultCode != FLT_NONE |-> physAddr == '0 && !outDirty);
endmodule

// File: tb/test_page_xlate.sv
`timescale 1ns/1ps
module test_page_xlate;
  localparam int ProcBits    = 2;
  localparam int PageRowBits = 8;
  localparam int Rows        = 1 << (ProcBits + PageRowBits);

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [31:0] linAddr = 0;
  logic [1:0] accType = 0;
  logic pagingEn = 0;
  logic privSup = 0;
  logic [ProcBits-1:0] curProc = 0;
  logic tblWe = 0;
  logic [ProcBits-1:0] tblProc = 0;
  logic [PageRowBits-1:0] tblPage = 0;
  logic [31:0] tblData = 0;
  logic outValid;
  logic [31:0] physAddr;
  logic [2:0] faultCode;
  logic outDirty;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [Rows];

  always #4 clk = ~clk;

  page_xlate #(.ProcBits(ProcBits), .PageRowBits(PageRowBits)) i_page_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .linAddr(linAddr),
    .accType(accType), .pagingEn(pagingEn), .privSup(privSup), .curProc(curProc),
    .tblWe(tblWe), .tblProc(tblProc), .tblPage(tblPage), .tblData(tblData),
    .outValid(outValid), .physAddr(physAddr), .faultCode(faultCode),
    .outDirty(outDirty)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expFault(input logic [31:0] lin, input logic [1:0] acc,
      input logic pg, input logic sup, input logic [ProcBits-1:0] proc, input logic [31:0] e);
    if (!pg) return 3'd0;
    if (lin[31:12] >= (1 << PageRowBits)) return 3'd4;
    if (proc == 0 || e[6:0] != 7'(proc)) return 3'd3;
    if (e[11] && !sup) return 3'd1;
    if (acc == 2'd1 && !e[10]) return 3'd2;
    return 3'd0;
  endfunction

  function automatic int rowOf(input logic [ProcBits-1:0] p, input logic [31:0] lin);
    return int'({p, lin[12 +: PageRowBits]});
  endfunction

  task automatic hostWrite(input logic sup, input logic [ProcBits-1:0] p,
      input logic [PageRowBits-1:0] pg, input logic [31:0] d);
    tblWe = 1; privSup = sup; tblProc = p; tblPage = pg; tblData = d;
    @(negedge clk);
    tblWe = 0;
    if (sup) model[int'({p, pg})] = d;   // R10: stored only with privilege
  endtask

  task automatic lookup(input string tag, input logic [31:0] lin, input logic [1:0] acc,
      input logic pg, input logic sup, input logic [ProcBits-1:0] proc);
    int r;
    logic [31:0] e;
    logic [2:0] f;
    logic [31:0] pa;
    logic dty;
    r = rowOf(proc, lin);
    e = model[r];
    f = expFault(lin, acc, pg, sup, proc, e);
    pa = !pg ? lin : (f == 0 ? {e[31:12], lin[11:0]} : 32'd0);
    dty = (pg && f == 0) ? e[9] : 1'b0;
    reqValid = 1; linAddr = lin; accType = acc; pagingEn = pg; privSup = sup; curProc = proc;
    @(negedge clk);
    reqValid = 0;
    chk({tag, " R2 early"}, 64'(outValid), 64'd0);
    @(negedge clk);
    chk({tag, " R2 valid"}, 64'(outValid), 64'd1);
    chk({tag, " R4 R5 R6 R7 fault"}, 64'(faultCode), 64'(f));
    chk({tag, " R1 R3 R8 addr"}, 64'(physAddr), 64'(pa));
    chk({tag, " R9 dirty"}, 64'(outDirty), 64'(dty));
    if (pg && f == 0 && acc == 2'd1) model[r][9] = 1'b1;
    @(negedge clk);
    chk({tag, " R2 pulse"}, 64'(outValid), 64'd0);
  endtask

  function automatic logic [31:0] mkEntry(input logic [19:0] base, input logic s,
      input logic w, input logic [6:0] own);
    return {base, s, w, 1'b0, 2'b00, own};
  endfunction

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < Rows; i++) model[i] = '0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R2 reset valid", 64'(outValid), 64'd0);
    // R12: table empty after reset, so any paged lookup misses the owner
    lookup("R12 empty", 32'h0000_0123, 2'd0, 1, 1, 2'd1);
    // R3: bypass
    lookup("R3 bypass", 32'hDEAD_BEEF, 2'd1, 0, 0, 2'd2);
    // R1: basic mapping
    hostWrite(1, 2'd1, 8'd5, mkEntry(20'hABCDE, 0, 1, 7'd1));
    lookup("R1 map", 32'h0000_5A5C, 2'd0, 1, 0, 2'd1);
    // R10: unprivileged write ignored
    hostWrite(0, 2'd1, 8'd5, mkEntry(20'h11111, 0, 1, 7'd1));
    lookup("R10 ignored", 32'h0000_5004, 2'd2, 1, 0, 2'd1);
    // R5: wrong process and process 0
    lookup("R5 other", 32'h0000_5004, 2'd0, 1, 1, 2'd2);
    hostWrite(1, 2'd0, 8'd3, mkEntry(20'h33333, 0, 1, 7'd0));
    lookup("R5 proc0", 32'h0000_3000, 2'd0, 1, 1, 2'd0);
    // R4: beyond region, also wins over owner mismatch
    lookup("R4 range", 32'h0010_0000, 2'd0, 1, 1, 2'd1);
    lookup("R4 prio", 32'h0000_0000 | (32'd1 << (12 + PageRowBits)), 2'd0, 1, 1, 2'd0);
    // R6 and R7 and their order
    hostWrite(1, 2'd2, 8'd7, mkEntry(20'h77777, 1, 0, 7'd2));
    lookup("R6 super", 32'h0000_7010, 2'd0, 1, 0, 2'd2);
    lookup("R6 prio", 32'h0000_7010, 2'd1, 1, 0, 2'd2);
    lookup("R7 wprot", 32'h0000_7010, 2'd1, 1, 1, 2'd2);
    lookup("R7 fetch ok", 32'h0000_7FFC, 2'd2, 1, 1, 2'd2);
    // R9: dirty set after a write, seen on next lookup
    lookup("R9 write", 32'h0000_5008, 2'd1, 1, 0, 2'd1);
    lookup("R9 seen", 32'h0000_500C, 2'd0, 1, 0, 2'd1);
    // R11: table write collides with a dirty update
    hostWrite(1, 2'd3, 8'd9, mkEntry(20'h99999, 0, 1, 7'd3));
    reqValid = 1; linAddr = 32'h0000_9000; accType = 2'd1; pagingEn = 1; privSup = 1; curProc = 2'd3;
    @(negedge clk);
    reqValid = 0;
    tblWe = 1; tblProc = 2'd3; tblPage = 8'd10; tblData = mkEntry(20'h0A0A0, 0, 1, 7'd3);
    @(negedge clk);
    tblWe = 0;
    model[int'({2'd3, 8'd10})] = mkEntry(20'h0A0A0, 0, 1, 7'd3);
    chk("R11 write result", 64'(faultCode), 64'd0);
    @(negedge clk);
    lookup("R11 dirty dropped", 32'h0000_9000, 2'd0, 1, 1, 2'd3);
    lookup("R11 host kept", 32'h0000_A123, 2'd0, 1, 1, 2'd3);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [ProcBits-1:0] p;
      logic [31:0] lin;
      p = ProcBits'($urandom % (1 << ProcBits));
      if ($urandom % 3 == 0) begin
        logic [6:0] own;
        own = ($urandom % 5 == 0) ? 7'($urandom % 8) : 7'(p);
        hostWrite(($urandom % 4) != 0, p, 8'($urandom % 16),
                  mkEntry(20'($urandom), 1'($urandom), 1'($urandom), own));
      end else begin
        lin = ($urandom % 8 == 0) ? {20'(256 + $urandom % 1000), 12'($urandom)}
                                  : {20'($urandom % 16), 12'($urandom)};
        lookup("rand", lin, 2'($urandom % 3), ($urandom % 6) != 0, 1'($urandom), p);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule